// File: doc/BRIEF.md
# Microstep Phase Sequencer

This block indexes the winding currents of a two-phase bipolar stepper motor. It keeps a 9-bit electrical angle, with 512 units per electrical cycle and 128 units per quarter wave. Each rising edge of the step input moves the angle forward or backward by a stride that the resolution code sets. From that angle the block produces two signed current ratios, in percent of full scale, one for each winding. It reads them from a quarter-wave sine table that it computes when the design is elaborated. A DAC and the bridge drivers downstream turn the ratios into coil current.

Eight resolutions share the one table by striding through it. They run from full step, with both windings always at full magnitude, down to 1/128 of a quarter wave. A chip-enable input puts the block in standby and returns it to its start position. An output-enable input blanks the ratios, but the angle keeps counting. An idle counter raises a flag that asks for a reduced holding current when no step edge has arrived for a set number of clock cycles.

Top module: `microstep_sequencer`

## Requirements
- R1: `mode_sel` = k (0..7) sets the stride for each step to 2^(7-k) angle units. Code 0 is full step (128 units), code 1 is half step (64), and code 7 is the finest (1 unit), so one electrical cycle takes 4·2^k steps.
- R2: After standby the angle is 0. The block then reports `ratio_a`=+100 and `ratio_b`=0, except in resolution code 0, where it reports +100/+100.
- R3: The angle changes exactly once for each rising edge of `step_in`, seen through a `SYNC_STAGES`-flop synchronizer. A held high level and a falling edge change nothing. The angle wraps modulo 512 in both directions.
- R4: With `dir_rev`=0 the angle increases and phase B lags phase A by 90 electrical degrees. With `dir_rev`=1 the angle decreases and B leads A.
- R5: The outputs are two's-complement 8-bit percentages. The angle splits into quadrant q = angle[8:7] and offset f = angle[6:0]. The magnitudes are S = T(f) and C = T(128-f), where T(i) = round(100·sin(i·90°/128)); for example T(32)=38, T(64)=71, T(96)=92. By quadrant: q=0 gives A=+C, B=+S; q=1 gives A=-S, B=+C; q=2 gives A=-C, B=-S; q=3 gives A=+S, B=-C.
- R6: In resolution code 0 both magnitudes are 100 at every angle, with the signs of R5. In code 1, an angle with f=64 also gives 100 on both phases.
- R7: While `out_en`=0, both ratios read 0 and `drive_en`=0, but step edges still move the angle. After re-enabling, the ratios show the updated angle.
- R8: While `chip_en`=0, the angle, the idle counter, `hold_flag` and the synchronizer clear, both ratios read 0 and `drive_en`=0.
- R9: `hold_flag` rises after `HOLD_CYCLES` clock cycles with no detected step edge. It clears on the clock edge after the next detected step edge.
- R10: The block latches `mode_sel` on each detected step edge, and continuously during standby. A change between step edges leaves the outputs unchanged. The stride of a step is the one for the code present at that step's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | High to run, low for standby and logic reset |
| out_en | input | 1 | High to present the ratios to the drivers |
| step_in | input | 1 | Step pulse input, asynchronous |
| dir_rev | input | 1 | 0 forward, 1 reverse |
| mode_sel | input | 3 | Resolution code 0..7 |
| ratio_a | output | 8 | Signed phase-A current ratio in percent |
| ratio_b | output | 8 | Signed phase-B current ratio in percent |
| drive_en | output | 1 | Bridge enable, high when both enables are high |
| hold_flag | output | 1 | Request for reduced holding current |

## Verification
The assertions check, on every cycle, the rules that hold step by step:
- the detected edge is a one-cycle pulse;
- the angle and the latched mode stay still between edges, and the angle moves on each edge;
- the ratios stay within ±100 and follow the quadrant signs;
- full step reports full magnitude on both phases;
- blanking and standby hold.

The bench's scenarios show what those local checks cannot:
- the exact table values across a full electrical cycle;
- the stride for each resolution code, and wrap-around in both directions;
- deferred mode changes;
- position tracking while the outputs are blanked;
- the length of the idle timeout.

// File: rtl/msq_pkg.sv
package msq_pkg;
  localparam int ANG_W    = 9;
  localparam int FRAC_W   = 7;
  localparam int QTR      = 1 << FRAC_W;
  localparam int FULL_PCT = 100;
  localparam int RATIO_W  = 8;

  typedef logic [ANG_W-1:0]          angle_t;
  typedef logic signed [RATIO_W-1:0] ratio_t;
  typedef logic [FRAC_W-1:0]         mag_t;

  typedef enum logic [2:0] {
    RES_FULL  = 3'd0,
    RES_HALF  = 3'd1,
    RES_DIV4  = 3'd2,
    RES_DIV8  = 3'd3,
    RES_DIV16 = 3'd4,
    RES_DIV32 = 3'd5,
    RES_DIV64 = 3'd6,
    RES_DIV128 = 3'd7
  } res_t;

  // round(100 * sin(idx * pi / 256)) with a fixed-point Taylor series (Q28)
  function automatic int sin_pct(int idx);
    longint pi_q, x, x2, term, acc;
    pi_q = 64'd843314857;
    x    = (longint'(idx) * pi_q) / 256;
    x2   = (x * x) >>> 28;
    term = x;
    acc  = x;
    for (int k = 1; k <= 6; k++) begin
      term = -(((term * x2) >>> 28) / longint'((2 * k) * (2 * k + 1)));
      acc  = acc + term;
    end
    return int'((acc * 100 + (64'sd1 <<< 27)) >>> 28);
  endfunction

  // angle units moved by one step for a resolution code
  function automatic angle_t stride_of(res_t m);
    return angle_t'(1) << (3'd7 - m);
  endfunction

  function automatic ratio_t apply_sign(mag_t mag, logic neg);
    ratio_t v;
    v = ratio_t'({1'b0, mag});
    return neg ? -v : v;
  endfunction
endpackage

// File: rtl/msq_step_edge.sv
module msq_step_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step_in,
  output logic step_rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else if (clear) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], step_in};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign step_rise = sync_q[SYNC_STAGES-1] & ~last_q;

  // R3: one detected edge is a single-cycle pulse
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n || clear)
    step_rise |=> !step_rise);
endmodule

// File: rtl/msq_phase_accum.sv
module msq_phase_accum
  import msq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear,
  input  logic   step_rise,
  input  logic   dir_rev,
  input  res_t   mode_in,
  output angle_t angle,
  output res_t   mode_q
);
  angle_t angle_q;
  angle_t stride;

  assign stride = stride_of(mode_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      angle_q <= '0;
      mode_q  <= RES_FULL;
    end else if (clear) begin
      angle_q <= '0;
      mode_q  <= mode_in;
    end else if (step_rise) begin
      angle_q <= dir_rev ? angle_q - stride : angle_q + stride;
      mode_q  <= mode_in;
    end
  end

  assign angle = angle_q;

  // R3: no movement without a detected edge
  p_still_between_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_rise && !clear) |=> $stable(angle_q));
  // R3: every detected edge moves the angle
  p_step_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_rise && !clear) |=> angle_q != $past(angle_q));
  // R10: resolution only changes on an edge or in standby
  p_mode_deferred_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_rise && !clear) |=> $stable(mode_q));
endmodule

// File: rtl/msq_hold_timer.sv
module msq_hold_timer #(
  parameter int HOLD_CYCLES = 60_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step_rise,
  output logic hold_flag
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

  logic [CNT_W-1:0] idle_cnt;
  logic             limit_hit;

  assign limit_hit = (idle_cnt == CNT_W'(HOLD_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      hold_flag <= 1'b0;
    end else if (clear || step_rise) begin
      idle_cnt  <= '0;
      hold_flag <= 1'b0;
    end else if (limit_hit) begin
      hold_flag <= 1'b1;
    end else begin
      idle_cnt  <= idle_cnt + 1'b1;
    end
  end

  // R9: the flag drops right after a step edge
  p_hold_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_rise |=> !hold_flag);
  // R9: the flag never rises on the cycle of a step edge
  p_hold_needs_idle_r9: assert property (@(posedge clk) disable iff (!rst_n || clear)
    $rose(hold_flag) |-> $past(!step_rise));
endmodule

// File: rtl/msq_ratio_lookup.sv
module msq_ratio_lookup
  import msq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  angle_t angle,
  input  res_t   mode_q,
  input  logic   enable,
  output ratio_t ratio_a,
  output ratio_t ratio_b
);
  mag_t rom [0:QTR];

  for (genvar g = 0; g <= QTR; g++) begin : g_rom
    assign rom[g] = mag_t'(sin_pct(g));
  end

  logic [1:0]        quad;
  logic [FRAC_W-1:0] frac;
  logic [FRAC_W:0]   lo_idx, hi_idx;
  logic              full_mag;
  mag_t              mag_sin, mag_cos;
  mag_t              a_mag, b_mag;
  logic              a_neg, b_neg;

  assign quad     = angle[ANG_W-1 -: 2];
  assign frac     = angle[FRAC_W-1:0];
  assign lo_idx   = {1'b0, frac};
  assign hi_idx   = (FRAC_W+1)'(QTR) - lo_idx;
  assign full_mag = (mode_q == RES_FULL) ||
                    (mode_q == RES_HALF && frac == FRAC_W'(QTR / 2));
  assign mag_sin  = full_mag ? mag_t'(FULL_PCT) : rom[lo_idx];
  assign mag_cos  = full_mag ? mag_t'(FULL_PCT) : rom[hi_idx];

  always_comb begin
    unique case (quad)
      2'd0: begin a_mag = mag_cos; a_neg = 1'b0; b_mag = mag_sin; b_neg = 1'b0; end
      2'd1: begin a_mag = mag_sin; a_neg = 1'b1; b_mag = mag_cos; b_neg = 1'b0; end
      2'd2: begin a_mag = mag_cos; a_neg = 1'b1; b_mag = mag_sin; b_neg = 1'b1; end
      default: begin a_mag = mag_sin; a_neg = 1'b0; b_mag = mag_cos; b_neg = 1'b1; end
    endcase
  end

  assign ratio_a = enable ? apply_sign(a_mag, a_neg) : '0;
  assign ratio_b = enable ? apply_sign(b_mag, b_neg) : '0;

  // R5: ratios never exceed full scale
  p_ratio_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_a <= 8'sd100 && ratio_a >= -8'sd100 && ratio_b <= 8'sd100 && ratio_b >= -8'sd100));
  // R5: third quadrant drives both phases non-positive
  p_third_quad_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && quad == 2'd2) |-> (ratio_a <= 0 && ratio_b <= 0));
  // R6: full-step resolution always gives full magnitude
  p_full_step_mag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mode_q == RES_FULL) |->
      ((ratio_a == 8'sd100 || ratio_a == -8'sd100) && (ratio_b == 8'sd100 || ratio_b == -8'sd100)));
endmodule

// File: rtl/microstep_sequencer.sv
module microstep_sequencer
  import msq_pkg::*;
#(
  parameter int HOLD_CYCLES = 60_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              out_en,
  input  logic              step_in,
  input  logic              dir_rev,
  input  logic [2:0]        mode_sel,
  output logic signed [7:0] ratio_a,
  output logic signed [7:0] ratio_b,
  output logic              drive_en,
  output logic              hold_flag
);
  logic   standby;
  logic   step_rise;
  angle_t angle;
  res_t   mode_q;

  assign standby  = !chip_en;
  assign drive_en = chip_en && out_en;

  msq_step_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .clear(standby), .step_in(step_in), .step_rise(step_rise)
  );

  msq_phase_accum u_accum (
    .clk(clk), .rst_n(rst_n), .clear(standby), .step_rise(step_rise),
    .dir_rev(dir_rev), .mode_in(res_t'(mode_sel)), .angle(angle), .mode_q(mode_q)
  );

  msq_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .clear(standby), .step_rise(step_rise), .hold_flag(hold_flag)
  );

  msq_ratio_lookup u_lookup (
    .clk(clk), .rst_n(rst_n), .angle(angle), .mode_q(mode_q), .enable(drive_en),
    .ratio_a(ratio_a), .ratio_b(ratio_b)
  );

  // R7: blanked outputs read zero
  p_blank_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> (ratio_a == 8'sd0 && ratio_b == 8'sd0));
  // R8: standby returns to the start angle and drops the hold request
  p_standby_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (angle == '0 && !hold_flag));
endmodule

// File: tb/microstep_sequencer_bench.sv
module microstep_sequencer_bench;
  localparam int HOLD = 64;
  localparam int NVEC = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0;
  logic out_en = 1'b1;
  logic step_in = 1'b0;
  logic dir_rev = 1'b0;
  logic [2:0] mode_sel = 3'd7;
  logic signed [7:0] ratio_a, ratio_b;
  logic drive_en, hold_flag;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  microstep_sequencer #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u_microstep_sequencer (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .out_en(out_en), .step_in(step_in),
    .dir_rev(dir_rev), .mode_sel(mode_sel), .ratio_a(ratio_a), .ratio_b(ratio_b),
    .drive_en(drive_en), .hold_flag(hold_flag)
  );

  // {mode[27:25], dir[24], steps[23:16], exp_a[15:8], exp_b[7:0]}, cumulative from angle 0
  localparam logic [27:0] VECS [NVEC] = '{
    {3'd7, 1'b0, 8'd1,  8'sd100,  8'sd1},
    {3'd7, 1'b0, 8'd31, 8'sd92,   8'sd38},
    {3'd7, 1'b0, 8'd32, 8'sd71,   8'sd71},
    {3'd2, 1'b0, 8'd1,  8'sd38,   8'sd92},
    {3'd2, 1'b0, 8'd1,  8'sd0,    8'sd100},
    {3'd1, 1'b0, 8'd1,  -8'sd100, 8'sd100},
    {3'd3, 1'b1, 8'd2,  -8'sd38,  8'sd92},
    {3'd0, 1'b0, 8'd1,  -8'sd100, -8'sd100},
    {3'd0, 1'b0, 8'd1,  8'sd100,  -8'sd100},
    {3'd0, 1'b0, 8'd1,  8'sd100,  8'sd100},
    {3'd4, 1'b1, 8'd5,  8'sd100,  -8'sd10},
    {3'd5, 1'b0, 8'd2,  8'sd100,  8'sd0},
    {3'd6, 1'b1, 8'd1,  8'sd100,  -8'sd2}
  };

  function automatic int mdl(int f);
    return $rtoi(100.0 * $sin(real'(f) * 3.141592653589793 / 256.0) + 0.5);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic chk2(string tag, int ea, int eb);
    n_chk++;
    if (int'(ratio_a) != ea || int'(ratio_b) != eb) begin
      n_fail++;
      $display("FAIL %s: a=%0d b=%0d expected a=%0d b=%0d", tag, ratio_a, ratio_b, ea, eb);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_step();
    @(negedge clk) step_in = 1'b1;
    repeat (3) @(negedge clk);
    step_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R8: standby state at start
    chk2("R8 standby ratios", 0, 0);
    chk1("R8 standby drive_en", drive_en, 1'b0);
    chk1("R8 standby hold_flag", hold_flag, 1'b0);
    chip_en = 1'b1;
    @(negedge clk);
    chk2("R2 start position", 100, 0);
    chk1("R7 drive_en on", drive_en, 1'b1);

    // vector table: R1 strides, R4 direction, R5 values, R6 full magnitude
    for (int i = 0; i < NVEC; i++) begin
      mode_sel = VECS[i][27:25];
      dir_rev  = VECS[i][24];
      for (int k = 0; k < int'(VECS[i][23:16]); k++) do_step();
      chk2($sformatf("R1 R4 R5 R6 vector %0d", i),
           int'($signed(VECS[i][15:8])), int'($signed(VECS[i][7:0])));
    end

    // R3: level and falling edge do nothing (angle 510 -> 511)
    mode_sel = 3'd7; dir_rev = 1'b0;
    @(negedge clk) step_in = 1'b1;
    repeat (4) @(negedge clk);
    chk2("R3 rising edge moves one unit", 100, -1);
    repeat (20) @(negedge clk);
    chk2("R3 held level no move", 100, -1);
    step_in = 1'b0;
    repeat (5) @(negedge clk);
    chk2("R3 falling edge no move", 100, -1);

    // R10: mode change without step keeps outputs, next step uses new stride
    mode_sel = 3'd0;
    repeat (5) @(negedge clk);
    chk2("R10 mode change deferred", 100, -1);
    do_step();
    chk2("R10 new stride at edge", 100, 100);

    // R7: blanking keeps counting
    out_en = 1'b0;
    @(negedge clk);
    chk2("R7 blanked ratios", 0, 0);
    chk1("R7 blanked drive_en", drive_en, 1'b0);
    mode_sel = 3'd7;
    do_step();
    chk2("R7 blanked after step", 0, 0);
    out_en = 1'b1;
    @(negedge clk);
    chk2("R7 resumes at advanced angle", 0, 100);

    // R9: idle timeout
    repeat (20) @(negedge clk);
    chk1("R9 no hold before timeout", hold_flag, 1'b0);
    repeat (60) @(negedge clk);
    chk1("R9 hold after timeout", hold_flag, 1'b1);
    do_step();
    chk1("R9 hold cleared by step", hold_flag, 1'b0);
    chk2("R9 step while holding moved", -1, 100);

    // R8 / R2: standby reset, then start in full step and fine mode
    repeat (80) @(negedge clk);
    chip_en = 1'b0; mode_sel = 3'd0;
    repeat (2) @(negedge clk);
    chk2("R8 standby ratios zero", 0, 0);
    chk1("R8 standby drive_en", drive_en, 1'b0);
    chk1("R8 standby clears hold", hold_flag, 1'b0);
    chip_en = 1'b1;
    @(negedge clk);
    chk2("R2 full-step start", 100, 100);
    dir_rev = 1'b1;
    do_step();
    chk2("R3 R4 reverse wrap below zero", 100, -100);
    chip_en = 1'b0; mode_sel = 3'd7; dir_rev = 1'b0;
    repeat (2) @(negedge clk);
    chip_en = 1'b1;
    @(negedge clk);
    chk2("R2 fine-mode start", 100, 0);

    // R5: full electrical cycle in finest resolution against a sine model
    for (int i = 1; i <= 512; i++) begin
      int ang, q, f, s, c, ea, eb;
      do_step();
      ang = i % 512; q = ang / 128; f = ang % 128;
      s = mdl(f); c = mdl(128 - f);
      case (q)
        0: begin ea = c;  eb = s;  end
        1: begin ea = -s; eb = c;  end
        2: begin ea = -c; eb = -s; end
        default: begin ea = s; eb = -c; end
      endcase
      chk2($sformatf("R5 sweep angle %0d", ang), ea, eb);
    end

    summary();
    $finish;
  end
endmodule